// File: doc/BRIEF.md
# Search Coprocessor Control Register

This block is the host-programmed control register of a search coprocessor that can be chained with identical devices to form a deeper table. The host writes a 9-bit word that sets the table-size code, the extra delay on the hit flags, and two flags that give the device's position in the chain. The same word also carries a device-enable bit and a self-clearing reset bit. The block decodes these fields onto dedicated outputs. From the table-size code and the hit delay it derives the pipeline latencies the rest of the device uses.

Writing a 1 into bit 0 starts an internal reset that lasts a fixed number of clock cycles. During that reset the combined reset output is asserted, exactly as a hardware reset would do, and the register fields return to their reset values. Host writes are dropped while the reset runs. Bit 0 reads back as 1 until the reset ends, and then it reads 0 again without any action from the host.

The enable bit is used at power-up to keep chained devices from contending on shared wiring. While it is clear, every output-enable control for the memory bus, the hit flags and the data bus is held low, and the cascade outputs are forced to zero. While it is set, each output enable follows its request. Two exceptions apply: the memory-bus enable is also raised on the last device of the memory bus, and the hit-flag enable is also raised on the last device of the chain, because each of those devices is the default driver of its signals.

Top module: `ctl_regblk`

## Requirements
- R1: After the hardware reset `rd_data` reads 0x004: table-size code 01, and every other field and bit 0. `cfg_err`, all output enables and both cascade outputs are low.
- R2: A write with bit 0 clear stores `wr_data[8:1]` in the cycle after the write edge. Bit 1 is enable, [3:2] the table-size code, [6:4] the hit delay, bit 7 the last-in-chain flag and bit 8 the last-on-memory-bus flag. The decoded field outputs and `rd_data` show the stored value.
- R3: A write with bit 0 set makes `rd_data[0]` read 1 for exactly PULSE_LEN (8) cycles, starting in the cycle after the write edge, and then read 0 again.
- R4: During that internal reset all fields hold their reset values, so `rd_data` reads 0x005.
- R5: Writes that arrive while the internal reset runs have no effect on any field or on the reset's length.
- R6: `core_rst` is high exactly when `rst` is high or the internal reset is running.
- R7: While enable is 0, `mem_oe`, `hit_oe` and `dq_oe` are 0 and `casc_lo_out`/`casc_hi_out` are 0, whatever the requests and cascade inputs are.
- R8: While enable is 1: `mem_oe` = `mem_req` | last-on-memory-bus flag; `hit_oe` = `hit_req` | last-in-chain flag; `dq_oe` = `dq_req`; and the cascade outputs equal their inputs.
- R9: `search_lat` is 4 + the table-size code for codes 00, 01 and 10, and 6 for code 11. `hit_total_lat` = `search_lat` + the hit delay.
- R10: Table-size code 11 is stored like any other value and raises `cfg_err` for as long as it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 9 | Write word |
| rd_data | output | 9 | Readback word, bit 0 = internal reset running |
| tbl_size | output | 2 | Table-size code |
| hit_lat | output | 3 | Extra hit-flag delay in cycles |
| last_casc | output | 1 | Last device in the chain |
| last_mem | output | 1 | Last device on the memory bus |
| search_lat | output | 4 | Search pipeline latency in cycles |
| hit_total_lat | output | 4 | Latency of the hit flags in cycles |
| cfg_err | output | 1 | Reserved table-size code is held |
| core_rst | output | 1 | Combined reset to the rest of the device |
| mem_req | input | 1 | Datapath request to drive the memory bus |
| hit_req | input | 1 | Datapath request to drive the hit flags |
| dq_req | input | 1 | Datapath request to drive the data bus |
| mem_oe | output | 1 | Memory address/strobe output enable |
| hit_oe | output | 1 | Hit flag output enable |
| dq_oe | output | 1 | Data bus output enable |
| casc_lo_in | input | 2 | 2-bit cascade group from the datapath |
| casc_hi_in | input | 3 | 3-bit cascade group from the datapath |
| casc_lo_out | output | 2 | Gated 2-bit cascade group |
| casc_hi_out | output | 3 | Gated 3-bit cascade group |

## Verification
A wrong pulse counter shows at once in `rd_data[0]` and `core_rst`: the reset window is one cycle longer or shorter than eight, or it never closes. A field register that takes a write during the reset, or that keeps its value through the reset, shows in the readback in the very next cycle. Enable gating and latency decoding are purely combinational after the field register, so any error appears in the same cycle as the stored value. Sweeping all 256 field values against every request pattern exposes this.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int REG_W = 9;

    typedef struct packed {
        logic       last_mem;
        logic       last_casc;
        logic [2:0] hit_lat;
        logic [1:0] tbl_size;
        logic       enable;
    } ctl_fields_t;

    localparam ctl_fields_t FIELDS_RST = '{
        last_mem:  1'b0,
        last_casc: 1'b0,
        hit_lat:   3'd0,
        tbl_size:  2'b01,
        enable:    1'b0
    };

    localparam logic [1:0] TSZ_RESERVED = 2'b11;

    function automatic logic [3:0] base_latency(input logic [1:0] tsz);
        logic [3:0] lat;
        if (tsz == TSZ_RESERVED) lat = 4'd6;
        else                     lat = 4'd4 + {2'b00, tsz};
        return lat;
    endfunction

endpackage

// File: rtl/ctl_softrst_timer.sv
module ctl_softrst_timer #(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

    // R3
    start_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= LAST));

    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != LAST) |=> busy && (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/ctl_field_reg.sv
module ctl_field_reg
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output ctl_fields_t       fields,
    output logic              start
);
    assign start = wr_en && wr_data[0] && !busy;

    always_ff @(posedge clk) begin
        if (rst || busy || start) begin
            fields <= FIELDS_RST;
        end else if (wr_en) begin
            fields <= ctl_fields_t'(wr_data[REG_W-1:1]);
        end
    end

    // R4 R5
    hold_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (fields == FIELDS_RST));

    // R2
    write_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[0] && !busy) |=> (fields == ctl_fields_t'($past(wr_data[REG_W-1:1]))));

endmodule

// File: rtl/ctl_bus_gate.sv
module ctl_bus_gate #(
    parameter int LO_W = 2,
    parameter int HI_W = 3
) (
    input  logic            enable,
    input  logic            last_mem,
    input  logic            last_casc,
    input  logic            mem_req,
    input  logic            hit_req,
    input  logic            dq_req,
    input  logic [LO_W-1:0] lo_in,
    input  logic [HI_W-1:0] hi_in,
    output logic            mem_oe,
    output logic            hit_oe,
    output logic            dq_oe,
    output logic [LO_W-1:0] lo_out,
    output logic [HI_W-1:0] hi_out
);
    always_comb begin
        mem_oe = enable && (mem_req || last_mem);
        hit_oe = enable && (hit_req || last_casc);
        dq_oe  = enable && dq_req;
    end

    for (genvar i = 0; i < LO_W; i++) begin : g_lo
        assign lo_out[i] = enable & lo_in[i];
    end
    for (genvar j = 0; j < HI_W; j++) begin : g_hi
        assign hi_out[j] = enable & hi_in[j];
    end

endmodule

// File: rtl/ctl_regblk.sv
module ctl_regblk
    import ctl_pkg::*;
#(
    parameter int PULSE_LEN = 8,
    parameter int LO_W      = 2,
    parameter int HI_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic [1:0]        tbl_size,
    output logic [2:0]        hit_lat,
    output logic              last_casc,
    output logic              last_mem,
    output logic [3:0]        search_lat,
    output logic [3:0]        hit_total_lat,
    output logic              cfg_err,
    output logic              core_rst,
    input  logic              mem_req,
    input  logic              hit_req,
    input  logic              dq_req,
    output logic              mem_oe,
    output logic              hit_oe,
    output logic              dq_oe,
    input  logic [LO_W-1:0]   casc_lo_in,
    input  logic [HI_W-1:0]   casc_hi_in,
    output logic [LO_W-1:0]   casc_lo_out,
    output logic [HI_W-1:0]   casc_hi_out
);
    ctl_fields_t fields;
    logic        busy;
    logic        start;

    ctl_field_reg u_fields (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .fields  (fields),
        .start   (start)
    );

    ctl_softrst_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy)
    );

    ctl_bus_gate #(.LO_W(LO_W), .HI_W(HI_W)) u_gate (
        .enable    (fields.enable),
        .last_mem  (fields.last_mem),
        .last_casc (fields.last_casc),
        .mem_req   (mem_req),
        .hit_req   (hit_req),
        .dq_req    (dq_req),
        .lo_in     (casc_lo_in),
        .hi_in     (casc_hi_in),
        .mem_oe    (mem_oe),
        .hit_oe    (hit_oe),
        .dq_oe     (dq_oe),
        .lo_out    (casc_lo_out),
        .hi_out    (casc_hi_out)
    );

    always_comb begin
        rd_data       = {fields, busy};
        tbl_size      = fields.tbl_size;
        hit_lat       = fields.hit_lat;
        last_casc     = fields.last_casc;
        last_mem      = fields.last_mem;
        search_lat    = base_latency(fields.tbl_size);
        hit_total_lat = search_lat + {1'b0, fields.hit_lat};
        cfg_err       = (fields.tbl_size == TSZ_RESERVED);
        core_rst      = rst || busy;
    end

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_data[1] |-> (!mem_oe && !hit_oe && !dq_oe && casc_lo_out == '0 && casc_hi_out == '0));

    // R6
    pulse_reset_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[0] |-> core_rst);

    // R9
    lat_order_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_total_lat >= search_lat) && (search_lat >= 4'd4) && (search_lat <= 4'd6));

endmodule

// File: tb/sim_ctl_regblk.sv
module sim_ctl_regblk;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [8:0] wr_data;
    logic [8:0] rd_data;
    logic [1:0] tbl_size;
    logic [2:0] hit_lat;
    logic       last_casc, last_mem;
    logic [3:0] search_lat, hit_total_lat;
    logic       cfg_err, core_rst;
    logic       mem_req, hit_req, dq_req;
    logic       mem_oe, hit_oe, dq_oe;
    logic [1:0] casc_lo_in, casc_lo_out;
    logic [2:0] casc_hi_in, casc_hi_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ctl_regblk u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tbl_size(tbl_size), .hit_lat(hit_lat), .last_casc(last_casc), .last_mem(last_mem),
        .search_lat(search_lat), .hit_total_lat(hit_total_lat), .cfg_err(cfg_err),
        .core_rst(core_rst), .mem_req(mem_req), .hit_req(hit_req), .dq_req(dq_req),
        .mem_oe(mem_oe), .hit_oe(hit_oe), .dq_oe(dq_oe),
        .casc_lo_in(casc_lo_in), .casc_hi_in(casc_hi_in),
        .casc_lo_out(casc_lo_out), .casc_hi_out(casc_hi_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // drive at negedge, let the posedge capture, sample 1 ns later
    task automatic cycle_write(input logic en, input logic [8:0] d);
        @(negedge clk);
        wr_en = en;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic check_fields(input logic [7:0] f, input bit pulse);
        int tsz, hl, base;
        tsz  = int'(f[2:1]);
        hl   = int'(f[5:3]);
        base = (tsz == 3) ? 6 : 4 + tsz;
        chk("R2 rd_data", int'(rd_data), int'({f, pulse}));
        chk("R2 tbl_size", int'(tbl_size), tsz);
        chk("R2 hit_lat", int'(hit_lat), hl);
        chk("R2 last_casc", int'(last_casc), int'(f[6]));
        chk("R2 last_mem", int'(last_mem), int'(f[7]));
        chk("R9 search_lat", int'(search_lat), base);
        chk("R9 hit_total_lat", int'(hit_total_lat), base + hl);
        chk("R10 cfg_err", int'(cfg_err), (tsz == 3) ? 1 : 0);
    endtask

    task automatic check_gate(input logic [7:0] f);
        for (int r = 0; r < 8; r++) begin
            mem_req = r[0]; hit_req = r[1]; dq_req = r[2];
            casc_lo_in = r[1:0]; casc_hi_in = 3'(7 - r);
            #0.5;
            if (!f[0]) begin
                chk("R7 oe", int'({mem_oe, hit_oe, dq_oe}), 0);
                chk("R7 casc", int'({casc_lo_out, casc_hi_out}), 0);
            end else begin
                chk("R8 mem_oe", int'(mem_oe), int'(r[0] | f[7]));
                chk("R8 hit_oe", int'(hit_oe), int'(r[1] | f[6]));
                chk("R8 dq_oe", int'(dq_oe), int'(r[2]));
                chk("R8 casc", int'({casc_lo_out, casc_hi_out}), int'({r[1:0], 3'(7 - r)}));
            end
        end
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        mem_req = 1'b1; hit_req = 1'b1; dq_req = 1'b1;
        casc_lo_in = 2'b11; casc_hi_in = 3'b111;
        repeat (3) @(posedge clk);
        #1;
        chk("R6 core_rst in hw reset", int'(core_rst), 1);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 rd_data", int'(rd_data), 9'h004);
        chk("R1 cfg_err", int'(cfg_err), 0);
        chk("R1 oe", int'({mem_oe, hit_oe, dq_oe}), 0);
        chk("R1 casc", int'({casc_lo_out, casc_hi_out}), 0);
        chk("R6 core_rst idle", int'(core_rst), 0);

        // R2 R7 R8 R9 R10 full sweep of the field word
        for (int v = 0; v < 256; v++) begin
            cycle_write(1'b1, {8'(v), 1'b0});
            check_fields(8'(v), 1'b0);
            check_gate(8'(v));
        end

        // R3 R4 R5 R6 internal reset pulse, with writes attempted inside it
        cycle_write(1'b1, {8'hFF, 1'b0});
        check_fields(8'hFF, 1'b0);
        cycle_write(1'b1, {8'hAA, 1'b1});
        for (int c = 0; c < 8; c++) begin
            chk("R3 pulse bit", int'(rd_data[0]), 1);
            chk("R4 fields held", int'(rd_data), 9'h005);
            chk("R6 core_rst pulse", int'(core_rst), 1);
            // R5 write ignored (alternate plain and re-trigger writes)
            cycle_write(1'b1, {8'h5A, c[0]});
        end
        chk("R3 self clear", int'(rd_data[0]), 0);
        chk("R5 no write stored", int'(rd_data), 9'h004);
        chk("R6 core_rst released", int'(core_rst), 0);
        cycle_write(1'b1, {8'h3C, 1'b0});
        check_fields(8'h3C, 1'b0);

        // R3 pulse with no writes inside it: exactly eight cycles
        cycle_write(1'b1, 9'h001);
        for (int c = 0; c < 8; c++) begin
            chk("R3 pulse length", int'(rd_data[0]), 1);
            @(posedge clk); #1;
        end
        chk("R3 pulse end", int'(rd_data[0]), 0);
        chk("R1 values after pulse", int'(rd_data), 9'h004);

        // R1 hardware reset clears a programmed register
        cycle_write(1'b1, {8'hE7, 1'b0});
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 hw reset", int'(rd_data), 9'h004);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 hw reset held", int'(rd_data), 9'h004);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule